// File: doc/BRIEF.md
# Transactional write-buffer cache

This block is a small, fully associative store that sits beside one processor's regular data cache and holds every line that processor touches inside a transaction. The CPU side issues transactional loads, load-exclusives and stores, and ends or checks the transaction with commit, abort and validate. A stored value is kept in a private entry that no other agent can see. The value the line had before the transaction stays visible beside it until the transaction ends. Commit keeps the new values and abort keeps the old ones. Either way, the whole entry array is switched over in one clock.

Other agents' accesses arrive on a snoop port. The block answers with the visible copy of a line when it holds one. It also reports, in the same cycle, whether the access collides with the transaction's read or write set. A collision latches a conflict flag. A later validate reports the flag, and a commit that finds it set is turned into an abort. Lines come from backing memory on a miss. A dirty committed line is written back when its entry is reused. If a new line is needed while every entry holds transactional state, the block signals overflow and aborts instead of dropping tentative data.

Top module: `tx_cache`

## Requirements
- R1: After reset every entry is empty: `req_ready` is 1, `resp_valid`, `overflow` and `mem_rd_req` are 0, a snoop of any address gives `snp_hit`=0, and validate answers `resp_ok`=1.
- R2: `req_op` codes are 1 load, 2 load-exclusive, 3 store, 4 commit, 5 validate, 6 abort. A load or load-exclusive compares its address with every entry at once. On a hit, `resp_valid` rises one clock edge after the accepting edge, with the line data. On a miss, `mem_rd_req` stays high with `mem_rd_addr` until `mem_rd_valid`, and then the fetched word is returned.
- R3: A store is tentative. Later loads of that address return the stored value. A snoop of the address returns the value from before the transaction. No memory write occurs for it.
- R4: Commit with no conflict answers `resp_ok`=1. After it, every line stored in the transaction is a normal line whose new value a snoop hits, and a snoop read of it no longer conflicts.
- R5: Abort answers `resp_ok`=1 and drops every stored value. Afterwards, loads and snoops of those lines see the pre-transaction value.
- R6: `snp_conflict` is 1 in the same cycle for a snoop write to any line in the read or write set, and for a snoop read to a line that was stored or load-exclusived. A snoop read of a line that was only loaded gives 0.
- R7: Validate answers `resp_ok`=1 only if no conflict has been seen since the last commit or abort. Commit while a conflict is flagged answers `resp_ok`=0 and behaves as abort. Either end clears the flag.
- R8: If a line needs an entry and none is empty or held by a non-transactional line, `overflow` pulses together with `resp_valid` and `resp_ok`=0, and all transactional state is aborted.
- R9: An entry reused while it holds a committed, modified line is first written to memory through `mem_wr_valid`/`mem_wr_addr`/`mem_wr_data`. A clean line is reused without a write.
- R10: Commit, abort and validate answer one edge after being accepted, and `req_ready` is 0 during that cycle, while all entries change state together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | AW | Line address of the request |
| req_wdata | input | DW | Store data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_ok | output | 1 | Success / validate status |
| resp_rdata | output | DW | Load data |
| overflow | output | 1 | Capacity overflow forced an abort |
| snp_valid | input | 1 | Snoop access present |
| snp_write | input | 1 | Snoop access is a write |
| snp_addr | input | AW | Snooped line address |
| snp_hit | output | 1 | A visible copy of the line is held |
| snp_conflict | output | 1 | The snoop collides with the transaction |
| snp_rdata | output | DW | Visible data of the snooped line |
| mem_rd_req | output | 1 | Line fetch request, held until data |
| mem_rd_addr | output | AW | Address to fetch |
| mem_rd_valid | input | 1 | Fetched data present |
| mem_rd_data | input | DW | Fetched data |
| mem_wr_valid | output | 1 | One-cycle write-back strobe |
| mem_wr_addr | output | AW | Write-back address |
| mem_wr_data | output | DW | Write-back data |

## Verification
A request taken at one rising edge is executed in the next cycle. Hits, stores to held lines, commit, abort, validate and overflow therefore raise `resp_valid` exactly one edge after the accepting edge. A miss adds the memory wait plus one fill edge before the same execute step. The snoop outputs are combinational in the cycle the snoop is driven, and the conflict flag it sets is registered at the following edge. For that reason, validate and commit are only issued after the snoop cycle has closed. The bench drives and samples at falling edges. It counts edges until the response strobe and checks the count for the fixed-latency cases, reads `req_ready` in the middle cycle, and reads the snoop outputs shortly after driving them.

// File: rtl/tx_pkg.sv
package tx_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_LOAD     = 3'd1,
        OP_LOADX    = 3'd2,
        OP_STORE    = 3'd3,
        OP_COMMIT   = 3'd4,
        OP_VALIDATE = 3'd5,
        OP_ABORT    = 3'd6,
        OP_RSVD     = 3'd7
    } op_e;

    // FREE: empty, NORM: visible line, XNEW: tentative value,
    // XOLD: value kept if the transaction is dropped
    typedef enum logic [1:0] {
        K_FREE = 2'd0,
        K_NORM = 2'd1,
        K_XNEW = 2'd2,
        K_XOLD = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EXEC = 2'd1,
        S_FILL = 2'd2
    } fsm_e;

endpackage

// File: rtl/tx_match.sv
module tx_match #(
    parameter int N_ENT = 8,
    parameter int AW    = 16
) (
    input  logic [AW-1:0]                 addr,
    input  logic [N_ENT-1:0][AW-1:0]      tags,
    input  tx_pkg::kind_e [N_ENT-1:0]     kinds,
    output logic [N_ENT-1:0]              hit_norm,
    output logic [N_ENT-1:0]              hit_xnew,
    output logic [N_ENT-1:0]              hit_xold
);
    import tx_pkg::*;

    // one comparator per entry, all working in parallel
    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        logic eq;
        assign eq          = (tags[i] == addr);
        assign hit_norm[i] = eq && (kinds[i] == K_NORM);
        assign hit_xnew[i] = eq && (kinds[i] == K_XNEW);
        assign hit_xold[i] = eq && (kinds[i] == K_XOLD);
    end

endmodule

// File: rtl/tx_pick.sv
module tx_pick #(
    parameter int N_ENT = 8,
    localparam int IW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0] vec,
    output logic             found,
    output logic [IW-1:0]    idx
);
    // lowest set position wins
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (vec[i]) idx = i[IW-1:0];
        end
    end

endmodule

// File: rtl/tx_cache.sv
module tx_cache #(
    parameter int N_ENT = 8,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          resp_valid,
    output logic          resp_ok,
    output logic [DW-1:0] resp_rdata,
    output logic          overflow,
    input  logic          snp_valid,
    input  logic          snp_write,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_hit,
    output logic          snp_conflict,
    output logic [DW-1:0] snp_rdata,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    input  logic [DW-1:0] mem_rd_data,
    output logic          mem_wr_valid,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data
);
    import tx_pkg::*;

    localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    typedef struct packed {
        kind_e         kind;
        logic          rset;
        logic          wset;
        logic          dirty;
        logic [AW-1:0] tag;
        logic [DW-1:0] data;
    } ent_t;

    typedef ent_t [N_ENT-1:0] ents_t;

    typedef struct packed {
        fsm_e          fsm;
        op_e           op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [IW-1:0] fill_idx;
        logic          conflict;
        logic          resp_valid;
        logic          resp_ok;
        logic [DW-1:0] resp_rdata;
        logic          overflow;
        logic          rd_req;
        logic          wr_valid;
        logic [AW-1:0] wr_addr;
        logic [DW-1:0] wr_data;
        ents_t         ents;
    } st_t;

    st_t q, d;

    // ---------------- entry field views ----------------
    logic [N_ENT-1:0][AW-1:0] tags;
    kind_e [N_ENT-1:0]        kinds;
    logic [N_ENT-1:0]         rset_v, wset_v, free_v, vict_v;

    // ---------------- match / pick results ----------------
    logic [N_ENT-1:0] cpu_hn, cpu_hx, cpu_ho;
    logic [N_ENT-1:0] snp_hn, snp_hx, snp_ho;
    logic             hn_any, hx_any, free_any, vic_any, svis_any;
    logic [IW-1:0]    hn_idx, hx_idx, free_idx, vic_idx, svis_idx;

    for (genvar i = 0; i < N_ENT; i++) begin : g_view
        assign tags[i]   = q.ents[i].tag;
        assign kinds[i]  = q.ents[i].kind;
        assign rset_v[i] = q.ents[i].rset;
        assign wset_v[i] = q.ents[i].wset;
        assign free_v[i] = (q.ents[i].kind == K_FREE);
        // a reusable visible line: outside the transaction, not the line being stored
        assign vict_v[i] = (q.ents[i].kind == K_NORM) && !q.ents[i].rset
                           && !q.ents[i].wset && !cpu_hn[i];
    end

    tx_match #(.N_ENT(N_ENT), .AW(AW)) u_cpu_match (
        .addr     (q.addr),
        .tags     (tags),
        .kinds    (kinds),
        .hit_norm (cpu_hn),
        .hit_xnew (cpu_hx),
        .hit_xold (cpu_ho)
    );

    tx_match #(.N_ENT(N_ENT), .AW(AW)) u_snp_match (
        .addr     (snp_addr),
        .tags     (tags),
        .kinds    (kinds),
        .hit_norm (snp_hn),
        .hit_xnew (snp_hx),
        .hit_xold (snp_ho)
    );

    tx_pick #(.N_ENT(N_ENT)) u_pick_hn   (.vec(cpu_hn),          .found(hn_any),   .idx(hn_idx));
    tx_pick #(.N_ENT(N_ENT)) u_pick_hx   (.vec(cpu_hx),          .found(hx_any),   .idx(hx_idx));
    tx_pick #(.N_ENT(N_ENT)) u_pick_free (.vec(free_v),          .found(free_any), .idx(free_idx));
    tx_pick #(.N_ENT(N_ENT)) u_pick_vic  (.vec(vict_v),          .found(vic_any),  .idx(vic_idx));
    tx_pick #(.N_ENT(N_ENT)) u_pick_svis (.vec(snp_hn | snp_ho), .found(svis_any), .idx(svis_idx));

    // ---------------- snoop side ----------------
    logic [N_ENT-1:0] snp_any;
    logic             snp_conf_now;

    assign snp_any      = snp_hn | snp_hx | snp_ho;
    assign snp_conf_now = snp_valid && (snp_write ? |(snp_any & (rset_v | wset_v))
                                                  : |(snp_any & wset_v));
    assign snp_conflict = snp_conf_now;
    assign snp_hit      = snp_valid && svis_any;
    assign snp_rdata    = snp_hit ? q.ents[svis_idx].data : '0;

    // ---------------- slot choice ----------------
    logic          slot_any;
    logic [IW-1:0] slot_idx;
    logic          slot_dirty;

    assign slot_any   = free_any || vic_any;
    assign slot_idx   = free_any ? free_idx : vic_idx;
    assign slot_dirty = !free_any && q.ents[vic_idx].dirty;

    // end of transaction: every entry updated at once
    function automatic ents_t end_tx(ents_t e, logic keep_new);
        ents_t r;
        r = e;
        for (int i = 0; i < N_ENT; i++) begin
            r[i].rset = 1'b0;
            r[i].wset = 1'b0;
            if (e[i].kind == K_XNEW) begin
                if (keep_new) begin
                    r[i].kind  = K_NORM;
                    r[i].dirty = 1'b1;
                end else begin
                    r[i].kind = K_FREE;
                end
            end else if (e[i].kind == K_XOLD) begin
                r[i].kind = keep_new ? K_FREE : K_NORM;
            end
        end
        return r;
    endfunction

    // ---------------- next state ----------------
    always_comb begin
        logic          need_fill;
        logic          need_ovf;
        logic          take_slot;
        logic          clean_now;
        logic [IW-1:0] hit_idx;

        d          = q;
        need_fill  = 1'b0;
        need_ovf   = 1'b0;
        take_slot  = 1'b0;
        clean_now  = !(q.conflict || snp_conf_now);
        hit_idx    = hx_any ? hx_idx : hn_idx;

        d.resp_valid = 1'b0;
        d.overflow   = 1'b0;
        d.wr_valid   = 1'b0;

        if (snp_conf_now) d.conflict = 1'b1;

        unique case (q.fsm)
            S_IDLE: begin
                if (req_valid) begin
                    d.fsm   = S_EXEC;
                    d.op    = op_e'(req_op);
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                end
            end

            S_FILL: begin
                if (mem_rd_valid) begin
                    d.ents[q.fill_idx].kind  = K_NORM;
                    d.ents[q.fill_idx].rset  = 1'b0;
                    d.ents[q.fill_idx].wset  = 1'b0;
                    d.ents[q.fill_idx].dirty = 1'b0;
                    d.ents[q.fill_idx].tag   = q.addr;
                    d.ents[q.fill_idx].data  = mem_rd_data;
                    d.rd_req = 1'b0;
                    d.fsm    = S_EXEC;
                end
            end

            S_EXEC: begin
                d.fsm        = S_IDLE;
                d.resp_valid = 1'b1;
                d.resp_ok    = 1'b1;
                d.resp_rdata = '0;
                case (q.op)
                    OP_LOAD, OP_LOADX: begin
                        if (hx_any || hn_any) begin
                            d.ents[hit_idx].rset = 1'b1;
                            if (q.op == OP_LOADX) d.ents[hit_idx].wset = 1'b1;
                            d.resp_rdata = q.ents[hit_idx].data;
                        end else if (slot_any) begin
                            need_fill = 1'b1;
                        end else begin
                            need_ovf = 1'b1;
                        end
                    end

                    OP_STORE: begin
                        if (hx_any) begin
                            d.ents[hx_idx].data = q.wdata;
                        end else if (hn_any) begin
                            if (slot_any) begin
                                take_slot                 = 1'b1;
                                d.ents[hn_idx].kind       = K_XOLD;
                                d.ents[hn_idx].wset       = 1'b1;
                                d.ents[slot_idx].kind     = K_XNEW;
                                d.ents[slot_idx].rset     = 1'b0;
                                d.ents[slot_idx].wset     = 1'b1;
                                d.ents[slot_idx].dirty    = 1'b0;
                                d.ents[slot_idx].tag      = q.addr;
                                d.ents[slot_idx].data     = q.wdata;
                            end else begin
                                need_ovf = 1'b1;
                            end
                        end else if (slot_any) begin
                            need_fill = 1'b1;
                        end else begin
                            need_ovf = 1'b1;
                        end
                    end

                    OP_COMMIT: begin
                        d.ents     = end_tx(q.ents, clean_now);
                        d.conflict = 1'b0;
                        d.resp_ok  = clean_now;
                    end

                    OP_ABORT: begin
                        d.ents     = end_tx(q.ents, 1'b0);
                        d.conflict = 1'b0;
                    end

                    OP_VALIDATE: begin
                        d.resp_ok = clean_now;
                    end

                    default: begin
                        d.resp_ok = 1'b0;
                    end
                endcase

                if (need_fill) begin
                    take_slot                    = 1'b1;
                    d.ents[slot_idx].kind        = K_FREE;
                    d.fill_idx                   = slot_idx;
                    d.rd_req                     = 1'b1;
                    d.fsm                        = S_FILL;
                    d.resp_valid                 = 1'b0;
                end

                if (take_slot && slot_dirty) begin
                    d.wr_valid = 1'b1;
                    d.wr_addr  = q.ents[vic_idx].tag;
                    d.wr_data  = q.ents[vic_idx].data;
                end

                if (need_ovf) begin
                    d.ents       = end_tx(q.ents, 1'b0);
                    d.conflict   = 1'b0;
                    d.overflow   = 1'b1;
                    d.resp_ok    = 1'b0;
                    d.resp_rdata = '0;
                end
            end

            default: d.fsm = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // ---------------- outputs ----------------
    assign req_ready    = (q.fsm == S_IDLE);
    assign resp_valid   = q.resp_valid;
    assign resp_ok      = q.resp_ok;
    assign resp_rdata   = q.resp_rdata;
    assign overflow     = q.overflow;
    assign mem_rd_req   = q.rd_req;
    assign mem_rd_addr  = q.addr;
    assign mem_wr_valid = q.wr_valid;
    assign mem_wr_addr  = q.wr_addr;
    assign mem_wr_data  = q.wr_data;

endmodule

// File: rtl/tx_cache_chk.sv
module tx_cache_chk #(
    parameter int N_ENT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [2:0]       req_op,
    input logic             resp_valid,
    input logic             resp_ok,
    input logic             overflow,
    input logic             snp_conflict,
    input logic             mem_rd_req,
    input logic             mem_rd_valid,
    input logic             conflict_flag,
    input logic [N_ENT-1:0] cpu_hits_vis,
    input logic [N_ENT-1:0] snp_hits_vis
);
    logic end_cmd;
    assign end_cmd = req_valid && req_ready &&
                     (req_op == 3'd4 || req_op == 3'd5 || req_op == 3'd6);

    // R3: one visible copy per line at most
    assert_single_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_hits_vis) && $onehot0(snp_hits_vis));

    // R2: a fetch stays requested until data arrives
    assert_fill_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> mem_rd_req);

    // R10: no request taken while entries switch
    assert_flush_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        end_cmd |=> !req_ready);

    assert_flush_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        end_cmd |-> ##2 resp_valid);

    // R8: overflow always reports failure
    assert_overflow_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (resp_valid && !resp_ok));

    // R7: a conflicting snoop while idle is remembered
    assert_conflict_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_conflict && req_ready) |=> conflict_flag);

endmodule

bind tx_cache tx_cache_chk #(.N_ENT(N_ENT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_op        (req_op),
    .resp_valid    (resp_valid),
    .resp_ok       (resp_ok),
    .overflow      (overflow),
    .snp_conflict  (snp_conflict),
    .mem_rd_req    (mem_rd_req),
    .mem_rd_valid  (mem_rd_valid),
    .conflict_flag (q.conflict),
    .cpu_hits_vis  (cpu_hn | cpu_ho),
    .snp_hits_vis  (snp_hn | snp_ho)
);

// File: tb/tb_tx_cache.sv
`timescale 1ns/1ps
module tb_tx_cache;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam logic [2:0] C_LD = 3'd1, C_LDX = 3'd2, C_ST = 3'd3,
                           C_CM = 3'd4, C_VAL = 3'd5, C_AB = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid = 0, req_ready;
    logic [2:0]    req_op = 0;
    logic [AW-1:0] req_addr = 0;
    logic [DW-1:0] req_wdata = 0;
    logic          resp_valid, resp_ok, overflow;
    logic [DW-1:0] resp_rdata;
    logic          snp_valid = 0, snp_write = 0;
    logic [AW-1:0] snp_addr = 0;
    logic          snp_hit, snp_conflict;
    logic [DW-1:0] snp_rdata;
    logic          mem_rd_req, mem_rd_valid = 0;
    logic [AW-1:0] mem_rd_addr;
    logic [DW-1:0] mem_rd_data = 0;
    logic          mem_wr_valid;
    logic [AW-1:0] mem_wr_addr;
    logic [DW-1:0] mem_wr_data;

    tx_cache dut (.*);

    int tests = 0, fails = 0;
    int rd_count = 0, wr_count = 0, wait_cnt = 0;
    logic [DW-1:0] model [0:255];

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        return 32'h5A00_0000 + {16'h0, a};
    endfunction

    // backing memory: answers a fetch on the third falling edge
    always @(negedge clk) begin
        if (mem_wr_valid) begin
            model[mem_wr_addr[7:0]] = mem_wr_data;
            wr_count++;
        end
        if (mem_rd_valid) begin
            mem_rd_valid = 1'b0;
            wait_cnt = 0;
        end else if (mem_rd_req) begin
            if (wait_cnt == 2) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = model[mem_rd_addr[7:0]];
                rd_count++;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic ok, output logic [DW-1:0] rd, output int lat,
                          output logic rdy_mid, output logic ovf);
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        rdy_mid = req_ready;
        lat = 0;
        while (!resp_valid && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        if (lat >= 300) chk("R2 response timeout", 0, 1);
        ok = resp_ok; rd = resp_rdata; ovf = overflow;
    endtask

    task automatic snoop(input logic [AW-1:0] a, input logic wr,
                         output logic hit, output logic conf, output logic [DW-1:0] data);
        @(negedge clk);
        snp_valid = 1; snp_write = wr; snp_addr = a;
        #1;
        hit = snp_hit; conf = snp_conflict; data = snp_rdata;
        @(negedge clk);
        snp_valid = 0;
    endtask

    logic ok, rdy, ovf, hit, conf;
    logic [DW-1:0] rd, sd;
    int lat;

    task automatic t_reset();
        chk("R1 req_ready", req_ready, 1);
        chk("R1 resp_valid", resp_valid, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 mem_rd_req", mem_rd_req, 0);
        snoop(16'h0010, 0, hit, conf, sd);
        chk("R1 snoop miss", hit, 0);
        do_req(C_VAL, 0, 0, ok, rd, lat, rdy, ovf);
        chk("R1 validate clean", ok, 1);
    endtask

    task automatic t_load();
        int r0;
        r0 = rd_count;
        do_req(C_LD, 16'h0010, 0, ok, rd, lat, rdy, ovf);
        chk("R2 miss data", rd, init_val(16'h0010));
        chk("R2 one fetch", rd_count - r0, 1);
        do_req(C_LD, 16'h0010, 0, ok, rd, lat, rdy, ovf);
        chk("R2 hit data", rd, init_val(16'h0010));
        chk("R2 hit latency", lat, 1);
        chk("R2 no refetch", rd_count - r0, 1);
        do_req(C_CM, 0, 0, ok, rd, lat, rdy, ovf);
        chk("R4 commit read-only", ok, 1);
    endtask

    task automatic t_store_conflict();
        do_req(C_ST, 16'h0020, 32'hDEAD_0001, ok, rd, lat, rdy, ovf);
        chk("R3 store ok", ok, 1);
        do_req(C_LD, 16'h0020, 0, ok, rd, lat, rdy, ovf);
        chk("R3 load sees own store", rd, 32'hDEAD_0001);
        snoop(16'h0020, 0, hit, conf, sd);
        chk("R3 snoop hit", hit, 1);
        chk("R3 snoop sees old value", sd, init_val(16'h0020));
        chk("R6 snoop read of stored line", conf, 1);
        chk("R3 no memory write", wr_count, 0);
        do_req(C_CM, 0, 0, ok, rd, lat, rdy, ovf);
        chk("R7 commit under conflict fails", ok, 0);
        do_req(C_LD, 16'h0020, 0, ok, rd, lat, rdy, ovf);
        chk("R7 failed commit discards store", rd, init_val(16'h0020));
        do_req(C_CM, 0, 0, ok, rd, lat, rdy, ovf);
        chk("R7 flag cleared by end", ok, 1);
    endtask

    task automatic t_commit();
        do_req(C_ST, 16'h0030, 32'hC0FF_EE00, ok, rd, lat, rdy, ovf);
        do_req(C_VAL, 0, 0, ok, rd, lat, rdy, ovf);
        chk("R7 validate no conflict", ok, 1);
        chk("R10 validate latency", lat, 1);
        do_req(C_CM, 0, 0, ok, rd, lat, rdy, ovf);
        chk("R4 commit ok", ok, 1);
        chk("R10 commit latency", lat, 1);
        chk("R10 busy during commit", rdy, 0);
        snoop(16'h0030, 0, hit, conf, sd);
        chk("R4 snoop hits committed", hit, 1);
        chk("R4 snoop data committed", sd, 32'hC0FF_EE00);
        chk("R4 no conflict after commit", conf, 0);
    endtask

    task automatic t_abort();
        do_req(C_ST, 16'h0040, 32'h1111_1111, ok, rd, lat, rdy, ovf);
        do_req(C_ST, 16'h0040, 32'h1234_5678, ok, rd, lat, rdy, ovf);
        do_req(C_LD, 16'h0040, 0, ok, rd, lat, rdy, ovf);
        chk("R3 second store replaces", rd, 32'h1234_5678);
        do_req(C_AB, 0, 0, ok, rd, lat, rdy, ovf);
        chk("R5 abort ok", ok, 1);
        chk("R10 busy during abort", rdy, 0);
        chk("R10 abort latency", lat, 1);
        do_req(C_LD, 16'h0040, 0, ok, rd, lat, rdy, ovf);
        chk("R5 load after abort", rd, init_val(16'h0040));
        snoop(16'h0040, 0, hit, conf, sd);
        chk("R5 snoop after abort", sd, init_val(16'h0040));
        do_req(C_CM, 0, 0, ok, rd, lat, rdy, ovf);
    endtask

    task automatic t_conflict_rules();
        do_req(C_LD, 16'h0050, 0, ok, rd, lat, rdy, ovf);
        snoop(16'h0050, 0, hit, conf, sd);
        chk("R6 read of read-set line", conf, 0);
        do_req(C_VAL, 0, 0, ok, rd, lat, rdy, ovf);
        chk("R7 validate after harmless snoop", ok, 1);
        snoop(16'h0050, 1, hit, conf, sd);
        chk("R6 write of read-set line", conf, 1);
        do_req(C_VAL, 0, 0, ok, rd, lat, rdy, ovf);
        chk("R7 validate after conflict", ok, 0);
        do_req(C_AB, 0, 0, ok, rd, lat, rdy, ovf);
        do_req(C_VAL, 0, 0, ok, rd, lat, rdy, ovf);
        chk("R7 flag cleared by abort", ok, 1);
        do_req(C_LDX, 16'h0060, 0, ok, rd, lat, rdy, ovf);
        chk("R2 load-exclusive data", rd, init_val(16'h0060));
        snoop(16'h0060, 0, hit, conf, sd);
        chk("R6 read of exclusive line", conf, 1);
        do_req(C_AB, 0, 0, ok, rd, lat, rdy, ovf);
    endtask

    task automatic t_overflow();
        int bad;
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            do_req(C_LD, 16'h0080 + 16'(i), 0, ok, rd, lat, rdy, ovf);
            if (rd !== init_val(16'h0080 + 16'(i)) || !ok || ovf) bad++;
        end
        chk("R8 eight lines fit", bad, 0);
        chk("R9 dirty victim written back", model[8'h30], 32'hC0FF_EE00);
        chk("R9 clean victims not written", wr_count, 1);
        do_req(C_LD, 16'h0088, 0, ok, rd, lat, rdy, ovf);
        chk("R8 overflow pulse", ovf, 1);
        chk("R8 overflow fails", ok, 0);
        chk("R8 overflow latency", lat, 1);
        do_req(C_LD, 16'h0088, 0, ok, rd, lat, rdy, ovf);
        chk("R8 retry after forced abort", ok, 1);
        chk("R8 retry data", rd, init_val(16'h0088));
        do_req(C_CM, 0, 0, ok, rd, lat, rdy, ovf);
        chk("R8 commit after retry", ok, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = init_val(16'(i));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_load();
        t_store_conflict();
        t_commit();
        t_abort();
        t_conflict_rules();
        t_overflow();
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule